// File: doc/BRIEF.md
# Indexed Configuration Window Redirector

This block is a register-bus slave that sits in front of an 8-byte device I/O window. The window holds two 32-bit registers: an index register at byte offsets 0 to 3 and a data register at byte offsets 4 to 7. When software writes the index register with a value inside a fixed aperture, the block latches an enable and a configuration offset. From then on, accesses that fit entirely inside the data register go to a local configuration-space port instead of the device. Every other access goes to the device port unchanged.

Index writes always reach the device, whatever their value. Redirected data writes never reach the device. Two sticky error flags record malformed accesses: an index write that starts past byte 0, and an access that only partly overlaps the data register. The access that raises a flag still completes.

The host issues one request at a time. A request is accepted when `host_ready` is high. The block forwards the request to exactly one downstream port and holds that request until the port acknowledges it. It then returns a one-cycle `host_ack` that carries the read data.

Top module: `cfg_window_redirect`

## Requirements
- R1: The host request carries a byte offset `host_addr` (0 to 7) and a size code `host_size`: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. `host_ready` is low from acceptance until completion. Completion is a one-cycle `host_ack` pulse, with read data on `host_rdata` and zero data for writes.
- R2: A write starting at offset 0 takes its data zero-extended from the access size. It enables the window when that value with bits 11:0 cleared equals 0x4000, and then stores bits 11:0 as the offset. Any other value at offset 0 disables the window and keeps the stored offset.
- R3: Every write starting at offset 0 is forwarded to the device with its offset, size and data unchanged, whether or not it matched.
- R4: While enabled, a read fully inside offsets 4 to 7 goes only to the configuration port. The configuration address is (stored offset + host_addr − 4) modulo 4096. The returned data is right-aligned, with bytes above the access size forced to zero.
- R5: While enabled, a write fully inside offsets 4 to 7 goes only to the configuration port, with its size and data. The device sees no request.
- R6: All other accesses, including every access while disabled, go to the device with offset, size and write data unchanged. Device read data is returned unmodified.
- R7: A write starting at offset 1, 2 or 3 sets `err_addr`. It does not change the enable or the offset, and it is still forwarded to the device.
- R8: An access whose last byte lies past offset 3 but which is not fully inside offsets 4 to 7 sets `err_data`. Such an access is forwarded to the device even while enabled.
- R9: Both error flags stay set until an `err_clr` pulse.
- R10: Reset disables the window, zeroes the offset and the flags, drops both downstream requests and raises `host_ready`.
- R11: At most one of `dev_req` and `cfg_req` is high. A downstream request stays high until its acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request strobe, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Byte offset within the window |
| host_size | input | 2 | Size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| host_wdata | input | 32 | Right-aligned write data |
| host_ready | output | 1 | Block can accept a request |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ack |
| dev_req | output | 1 | Device request, held until dev_ack |
| dev_we | output | 1 | Device write flag |
| dev_addr | output | 3 | Device byte offset |
| dev_size | output | 2 | Device size code |
| dev_wdata | output | 32 | Device write data |
| dev_ack | input | 1 | Device completion |
| dev_rdata | input | 32 | Device read data, valid with dev_ack |
| cfg_req | output | 1 | Configuration request, held until cfg_ack |
| cfg_we | output | 1 | Configuration write flag |
| cfg_addr | output | 12 | Configuration byte address |
| cfg_size | output | 2 | Configuration size code |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Configuration completion |
| cfg_rdata | input | 32 | Right-aligned configuration read data |
| err_clr | input | 1 | Clears both error flags |
| err_addr | output | 1 | Sticky flag for a misaligned index write |
| err_data | output | 1 | Sticky flag for a partial data-register access |

## Verification
The enable bit and the stored offset are invisible until the next data-register access. At that access, a wrong enable shows as the request appearing on the wrong downstream port. A wrong offset shows as a wrong `cfg_addr` on that same request. Either fault is therefore visible within one access of the corruption. A misrouted write is caught in two ways: by the downstream write counters, and by a device copy that arrives when none should. A wrong error decision shows on the flags before `host_ack` of the access that caused it.

// File: rtl/cfg_window_redirect.sv
module cfg_window_redirect #(
  parameter int          OFF_W = 12,
  parameter logic [31:0] MATCH = 32'h0000_4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_we,
  input  logic [2:0]       host_addr,
  input  logic [1:0]       host_size,
  input  logic [31:0]      host_wdata,
  output logic             host_ready,
  output logic             host_ack,
  output logic [31:0]      host_rdata,
  output logic             dev_req,
  output logic             dev_we,
  output logic [2:0]       dev_addr,
  output logic [1:0]       dev_size,
  output logic [31:0]      dev_wdata,
  input  logic             dev_ack,
  input  logic [31:0]      dev_rdata,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [OFF_W-1:0] cfg_addr,
  output logic [1:0]       cfg_size,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_ack,
  input  logic [31:0]      cfg_rdata,
  input  logic             err_clr,
  output logic             err_addr,
  output logic             err_data
);

  localparam logic [31:0] OFF_MASK = (32'd1 << OFF_W) - 32'd1;

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  logic             busy;
  logic             win_en;
  logic [OFF_W-1:0] win_off;
  logic             req_we;
  logic [2:0]       req_addr;
  logic [1:0]       req_size;
  logic [31:0]      req_wdata;

  logic [2:0]  nbytes;
  logic [3:0]  acc_end;
  logic        in_data, hits_data, accept, idx_wr, mis_wr, hit, redirect;
  logic [31:0] wval;

  assign nbytes    = (host_size == 2'd0) ? 3'd1 : (host_size == 2'd1) ? 3'd2 : 3'd4;
  assign acc_end   = {1'b0, host_addr} + {1'b0, nbytes};
  assign in_data   = host_addr[2] && (acc_end <= 4'd8);
  assign hits_data = acc_end > 4'd4;
  assign accept    = host_req && !busy;
  assign idx_wr    = host_we && (host_addr == 3'd0);
  assign mis_wr    = host_we && !host_addr[2] && (host_addr != 3'd0);
  assign wval      = host_wdata & size_mask(host_size);
  assign hit       = (wval & ~OFF_MASK) == MATCH;
  assign redirect  = win_en && in_data;

  assign host_ready = !busy;
  assign dev_we     = req_we;
  assign dev_addr   = req_addr;
  assign dev_size   = req_size;
  assign dev_wdata  = req_wdata;
  assign cfg_we     = req_we;
  assign cfg_size   = req_size;
  assign cfg_wdata  = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      win_en     <= 1'b0;
      win_off    <= '0;
      req_we     <= 1'b0;
      req_addr   <= '0;
      req_size   <= '0;
      req_wdata  <= '0;
      dev_req    <= 1'b0;
      cfg_req    <= 1'b0;
      cfg_addr   <= '0;
      host_ack   <= 1'b0;
      host_rdata <= '0;
      err_addr   <= 1'b0;
      err_data   <= 1'b0;
    end else begin
      host_ack <= 1'b0;
      err_addr <= (accept && mis_wr) || (err_addr && !err_clr);
      err_data <= (accept && hits_data && !in_data) || (err_data && !err_clr);

      if (accept) begin
        busy      <= 1'b1;
        req_we    <= host_we;
        req_addr  <= host_addr;
        req_size  <= host_size;
        req_wdata <= host_wdata;
        cfg_addr  <= win_off + {{(OFF_W-2){1'b0}}, host_addr[1:0]};
        if (redirect) cfg_req <= 1'b1;
        else          dev_req <= 1'b1;
        if (idx_wr) begin
          win_en <= hit;
          if (hit) win_off <= wval[OFF_W-1:0];
        end
      end

      if (dev_req && dev_ack) begin
        dev_req    <= 1'b0;
        busy       <= 1'b0;
        host_ack   <= 1'b1;
        host_rdata <= req_we ? 32'd0 : dev_rdata;
      end

      if (cfg_req && cfg_ack) begin
        cfg_req    <= 1'b0;
        busy       <= 1'b0;
        host_ack   <= 1'b1;
        host_rdata <= req_we ? 32'd0 : (cfg_rdata & size_mask(req_size));
      end
    end
  end

endmodule

// File: rtl/cfg_window_redirect_chk.sv
module cfg_window_redirect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_req,
  input logic       host_we,
  input logic [2:0] host_addr,
  input logic       host_ready,
  input logic       host_ack,
  input logic       dev_req,
  input logic       dev_ack,
  input logic       cfg_req,
  input logic       cfg_ack,
  input logic       err_clr,
  input logic       err_addr,
  input logic       err_data
);

  a_r11_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dev_req, cfg_req}) <= 1);

  a_r11_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req && !dev_ack |=> dev_req);

  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req);

  a_r1_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req || cfg_req) |-> !host_ready);

  a_r3_index_to_dev: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && host_ready && host_we && host_addr == 3'd0 |=> dev_req && !cfg_req);

  a_r7_misaligned_flag: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && host_ready && host_we && !host_addr[2] && host_addr != 3'd0 |=> err_addr);

  a_r9_addr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_addr && !err_clr |=> err_addr);

  a_r9_data_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_data && !err_clr |=> err_data);

endmodule

bind cfg_window_redirect cfg_window_redirect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
  .host_addr(host_addr), .host_ready(host_ready), .host_ack(host_ack),
  .dev_req(dev_req), .dev_ack(dev_ack), .cfg_req(cfg_req), .cfg_ack(cfg_ack),
  .err_clr(err_clr), .err_addr(err_addr), .err_data(err_data)
);

// File: tb/test_cfg_window_redirect.sv
module test_cfg_window_redirect;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, host_ack;
  logic [31:0] host_rdata;
  logic        dev_req, dev_we;
  logic [2:0]  dev_addr;
  logic [1:0]  dev_size;
  logic [31:0] dev_wdata;
  logic        dev_ack = 1'b0;
  logic [31:0] dev_rdata = '0;
  logic        cfg_req, cfg_we;
  logic [11:0] cfg_addr;
  logic [1:0]  cfg_size;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic        err_clr = 1'b0;
  logic        err_addr, err_data;

  cfg_window_redirect i_cfg_window_redirect (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int dev_wr_n = 0, dev_rd_n = 0, cfg_wr_n = 0, cfg_rd_n = 0;
  int dcnt = 0, dlat = 0, ccnt = 0, clat = 1;
  logic [2:0]  dl_addr;
  logic [1:0]  dl_size;
  logic [31:0] dl_wdata, cl_wdata;
  logic [11:0] cl_addr;
  logic [1:0]  cl_size;
  logic        m_en = 1'b0;
  logic [11:0] m_off = '0;

  function automatic logic [31:0] cfg_fn(input logic [11:0] a);
    cfg_fn = {8'hC3, 4'h0, a, 8'h96};
  endfunction
  function automatic logic [31:0] dev_fn(input logic [2:0] a);
    dev_fn = {16'hDE5A, 13'h0, a};
  endfunction
  function automatic logic [31:0] smask(input logic [1:0] s);
    smask = (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    dev_ack <= 1'b0;
    if (dev_req && !dev_ack) begin
      if (dcnt >= dlat) begin
        dev_ack <= 1'b1; dcnt <= 0; dlat <= (dlat + 1) % 3;
        dev_rdata <= dev_fn(dev_addr);
        dl_addr <= dev_addr; dl_size <= dev_size; dl_wdata <= dev_wdata;
        if (dev_we) dev_wr_n <= dev_wr_n + 1; else dev_rd_n <= dev_rd_n + 1;
      end else dcnt <= dcnt + 1;
    end
  end

  always @(posedge clk) begin
    cfg_ack <= 1'b0;
    if (cfg_req && !cfg_ack) begin
      if (ccnt >= clat) begin
        cfg_ack <= 1'b1; ccnt <= 0; clat <= (clat + 1) % 3;
        cfg_rdata <= cfg_fn(cfg_addr);
        cl_addr <= cfg_addr; cl_size <= cfg_size; cl_wdata <= cfg_wdata;
        if (cfg_we) cfg_wr_n <= cfg_wr_n + 1; else cfg_rd_n <= cfg_rd_n + 1;
      end else ccnt <= ccnt + 1;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic access(input logic we, input logic [2:0] a, input logic [1:0] s,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_size = s; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    while (!host_ack) @(negedge clk);
    rd = host_rdata;
  endtask

  task automatic clear_flags;
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic run(input logic we, input logic [2:0] a, input logic [1:0] s, input logic [31:0] wd);
    int dw0, dr0, cw0, cr0, n, e;
    logic cont, redir, exp_ea, exp_ed;
    logic [31:0] rd, v;
    string rt;
    clear_flags();
    dw0 = dev_wr_n; dr0 = dev_rd_n; cw0 = cfg_wr_n; cr0 = cfg_rd_n;
    n = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    e = int'(a) + n;
    cont = (a >= 3'd4) && (e <= 8);
    redir = m_en && cont;
    exp_ea = we && (a >= 3'd1) && (a <= 3'd3);
    exp_ed = (e > 4) && !cont;
    rt = redir ? (we ? "R5" : "R4") : ((we && a == 3'd0) ? "R3" : (exp_ed ? "R8" : "R6"));
    access(we, a, s, wd, rd);
    chk("R7", "err_addr", {31'd0, err_addr}, {31'd0, exp_ea});
    chk("R8", "err_data", {31'd0, err_data}, {31'd0, exp_ed});
    if (redir) begin
      chk(rt, "dev count", dev_wr_n + dev_rd_n, dw0 + dr0);
      chk(rt, "cfg count", we ? cfg_wr_n : cfg_rd_n, we ? cw0 + 1 : cr0 + 1);
      chk(rt, "cfg_addr", {20'd0, cl_addr}, {20'd0, m_off + {10'd0, a[1:0]}});
      if (we) chk(rt, "cfg_wdata", cl_wdata, wd);
      else    chk(rt, "rdata", rd, cfg_fn(m_off + {10'd0, a[1:0]}) & smask(s));
    end else begin
      chk(rt, "cfg count", cfg_wr_n + cfg_rd_n, cw0 + cr0);
      chk(rt, "dev count", we ? dev_wr_n : dev_rd_n, we ? dw0 + 1 : dr0 + 1);
      chk(rt, "dev fields", {dl_addr, dl_size}, {a, s});
      if (we) chk(rt, "dev_wdata", dl_wdata, wd);
      else    chk(rt, "rdata", rd, dev_fn(a));
    end
    if (we && a == 3'd0) begin
      v = wd & smask(s);
      if ((v & ~32'hFFF) == 32'h4000) begin m_en = 1'b1; m_off = v[11:0]; end
      else m_en = 1'b0;
    end
  endtask

  task automatic probe(input string tag, input logic exp_cfg, input logic [11:0] exp_a);
    int c0;
    logic [31:0] rd;
    c0 = cfg_rd_n;
    access(1'b0, 3'd4, 2'd2, 32'd0, rd);
    chk(tag, "probe routed to cfg", {31'd0, cfg_rd_n == c0 + 1}, {31'd0, exp_cfg});
    if (exp_cfg) chk(tag, "probe cfg_addr", {20'd0, cl_addr}, {20'd0, exp_a});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    report();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "host_ready", {31'd0, host_ready}, 32'd1);
    chk("R10", "requests", {30'd0, dev_req, cfg_req}, 32'd0);
    chk("R10", "flags", {30'd0, err_addr, err_data}, 32'd0);
    probe("R10", 1'b0, 12'h0);

    // R2 match boundaries
    run(1'b1, 3'd0, 2'd2, 32'h0000_3FFF); probe("R2", 1'b0, 12'h0);
    run(1'b1, 3'd0, 2'd2, 32'h0000_4000); probe("R2", 1'b1, 12'h000);
    run(1'b1, 3'd0, 2'd2, 32'h0000_4FFF); probe("R2", 1'b1, 12'hFFF);
    run(1'b1, 3'd0, 2'd2, 32'h0000_5000); probe("R2", 1'b0, 12'h0);
    run(1'b1, 3'd0, 2'd2, 32'h0001_4000); probe("R2", 1'b0, 12'h0);
    run(1'b1, 3'd0, 2'd1, 32'hFFFF_4ABC); probe("R2", 1'b1, 12'hABC);
    run(1'b1, 3'd0, 2'd0, 32'h0000_4055); probe("R2", 1'b0, 12'h0);

    // R7 misaligned index write keeps state
    run(1'b1, 3'd0, 2'd2, 32'h0000_4020);
    run(1'b1, 3'd1, 2'd0, 32'h0000_0000);
    probe("R7", 1'b1, 12'h020);

    // R9 sticky flags
    clear_flags();
    access(1'b1, 3'd2, 2'd2, 32'h1111_2222, rd);
    access(1'b0, 3'd0, 2'd2, 32'd0, rd);
    chk("R9", "err_addr held", {31'd0, err_addr}, 32'd1);
    chk("R9", "err_data held", {31'd0, err_data}, 32'd1);
    clear_flags();
    chk("R9", "flags cleared", {30'd0, err_addr, err_data}, 32'd0);

    // Sweep: all offsets, sizes, directions, with window on and off
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 8; a++)
        for (int s = 0; s < 3; s++)
          for (int w = 0; w < 2; w++) begin
            logic [11:0] off;
            off = 12'hFF0 + 12'(a * 2);
            run(1'b1, 3'd0, 2'd2, (p == 1) ? (32'h0000_4000 | {20'd0, off}) : 32'h0000_3000);
            run(w[0], a[2:0], s[1:0], 32'h0000_4000 | 32'(a * 32'h111 + s * 32'h40));
          end

    // R10 reset disables an enabled window
    run(1'b1, 3'd0, 2'd2, 32'h0000_4100);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_en = 1'b0; m_off = '0;
    chk("R10", "flags after reset", {30'd0, err_addr, err_data}, 32'd0);
    probe("R10", 1'b0, 12'h0);

    report();
  end
endmodule